// File: doc/BRIEF.md
# Dual-Bank Buffer RAM Arbiter

This block fronts two 8-Kbyte SRAM banks. Each bank is shared between a processor slave port and one read-only streaming client. Bank 0 feeds a color-table reader and bank 1 feeds an inverse-transform coefficient reader. The processor sees both banks as one 16-Kbyte window at the bottom of its byte address space. It moves data in bursts of one to eight 32-bit beats, and it is refused anything narrower than a word.

Each bank has its own arbiter, and the two share no state. Traffic on one bank therefore never holds up the other, and both streaming readers can fetch every cycle at the same time. Within one bank, a streaming reader wins a contended cycle whenever no processor burst is in flight. Once the processor wins the first beat of a burst, it keeps the bank until the burst ends. Every port uses a request/grant handshake. Read data returns one cycle after the grant, marked by a valid strobe.

Top module: `dbuf_arbiter`

## Requirements
- R1: Byte offsets 0x0000 to 0x1FFF of the window select bank 0, and 0x2000 to 0x3FFF select bank 1. Address bit 13 picks the bank and bits 12:2 pick the word.
- R2: cpu_size holds the log2 of the byte count. Codes 2, 3, 4 and 5 (4, 8, 16 and 32 bytes) are accepted and move 1, 2, 4 and 8 beats at consecutive word addresses, one beat per cpu_gnt.
- R3: Size codes 0, 1, 6 and 7 raise cpu_err in the request cycle. They give no grant, no read data and no change to either bank.
- R4: A start address not aligned to the access size, or any address at or above 0x4000, gets the same error response as R3 and leaves both banks unchanged.
- R5: When no processor burst is in flight and the processor and a bank's streaming reader request that bank in the same cycle, the reader is granted and the processor waits.
- R6: After the first beat of a processor burst is granted, every remaining beat is granted in the following cycles. The streaming reader of that bank is refused until the last beat.
- R7: On every port, read data and its valid strobe appear exactly one cycle after the grant of a read.
- R8: A processor access to one bank never stops the other bank's reader from being granted. Both readers requesting together are both granted.
- R9: After reset no read-valid strobe is high and no burst is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held for the whole burst |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 3 | log2 of the access size in bytes |
| cpu_addr | input | 16 | Start byte address of the burst |
| cpu_wdata | input | 32 | Write data of the current beat |
| cpu_gnt | output | 1 | Current beat accepted |
| cpu_err | output | 1 | Access refused (size, alignment or range) |
| cpu_rvalid | output | 1 | Processor read data valid |
| cpu_rdata | output | 32 | Processor read data |
| tu0_req | input | 1 | Bank 0 reader request |
| tu0_addr | input | 11 | Bank 0 word address |
| tu0_gnt | output | 1 | Bank 0 reader granted |
| tu0_rvalid | output | 1 | Bank 0 reader data valid |
| tu0_rdata | output | 32 | Bank 0 reader data |
| tu1_req | input | 1 | Bank 1 reader request |
| tu1_addr | input | 11 | Bank 1 word address |
| tu1_gnt | output | 1 | Bank 1 reader granted |
| tu1_rvalid | output | 1 | Bank 1 reader data valid |
| tu1_rdata | output | 32 | Bank 1 reader data |

## Verification
The burst-hold property assumes that the processor keeps cpu_req, cpu_we, cpu_size and cpu_addr steady from the first grant to the last beat. It also assumes that a refused access is withdrawn after its error cycle. The stimulus drops the request only after the final grant of a burst or after an error, and it changes only cpu_wdata between beats. Single-cycle vectors use one-beat reads or refused sizes, so none of them leaves a burst open for the next vector.

// File: rtl/dbuf_arbiter.sv
module dbuf_arbiter #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int BANK_BYTES = 8192,
  parameter int WIN_IDX    = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [2:0]           cpu_size,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic                 cpu_gnt,
  output logic                 cpu_err,
  output logic                 cpu_rvalid,
  output logic [DATA_W-1:0]    cpu_rdata,
  input  logic                 tu0_req,
  input  logic [$clog2(BANK_BYTES/(DATA_W/8))-1:0] tu0_addr,
  output logic                 tu0_gnt,
  output logic                 tu0_rvalid,
  output logic [DATA_W-1:0]    tu0_rdata,
  input  logic                 tu1_req,
  input  logic [$clog2(BANK_BYTES/(DATA_W/8))-1:0] tu1_addr,
  output logic                 tu1_gnt,
  output logic                 tu1_rvalid,
  output logic [DATA_W-1:0]    tu1_rdata
);
  localparam int OFF_W   = $clog2(DATA_W/8);
  localparam int WORDS   = BANK_BYTES/(DATA_W/8);
  localparam int BANK_AW = $clog2(WORDS);
  localparam int SEL_BIT = $clog2(BANK_BYTES);
  localparam int WIN_W   = SEL_BIT + 1;
  localparam int ALN_W   = OFF_W + 3;

  logic             in_burst;
  logic [2:0]       beat;
  logic [ALN_W-1:0] amask;
  logic             rd_bank;

  always_comb
    for (int i = 0; i < ALN_W; i++) amask[i] = (i < int'(cpu_size));

  wire size_ok   = int'(cpu_size) >= OFF_W && int'(cpu_size) <= OFF_W + 3;
  wire misal     = |(cpu_addr[ALN_W-1:0] & amask);
  wire in_win    = cpu_addr[ADDR_W-1:WIN_W] == (ADDR_W-WIN_W)'(WIN_IDX);
  wire bad       = !size_ok || misal || !in_win;
  wire cpu_bank  = cpu_addr[SEL_BIT];
  wire [2:0] last_beat = 3'((4'd1 << (cpu_size - 3'(OFF_W))) - 4'd1);
  wire [BANK_AW-1:0] cpu_word = cpu_addr[SEL_BIT-1:OFF_W] + BANK_AW'(beat);
  wire conflict  = cpu_bank ? tu1_req : tu0_req;
  wire cpu_last  = cpu_gnt && beat == last_beat;

  assign cpu_gnt = cpu_req && (in_burst || (!bad && !conflict));
  assign cpu_err = cpu_req && !in_burst && bad;
  assign tu0_gnt = tu0_req && !(cpu_gnt && !cpu_bank);
  assign tu1_gnt = tu1_req && !(cpu_gnt && cpu_bank);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_burst   <= 1'b0;
      beat       <= '0;
      cpu_rvalid <= 1'b0;
      tu0_rvalid <= 1'b0;
      tu1_rvalid <= 1'b0;
      rd_bank    <= 1'b0;
    end else begin
      if (cpu_gnt) begin
        in_burst <= !cpu_last;
        beat     <= cpu_last ? 3'd0 : beat + 3'd1;
      end
      cpu_rvalid <= cpu_gnt && !cpu_we;
      rd_bank    <= cpu_bank;
      tu0_rvalid <= tu0_gnt;
      tu1_rvalid <= tu1_gnt;
    end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] q;
    wire               own  = cpu_gnt && (int'(cpu_bank) == b);
    wire [BANK_AW-1:0] addr = own ? cpu_word : (b == 0 ? tu0_addr : tu1_addr);
    always_ff @(posedge clk) begin
      if (own && cpu_we) mem[addr] <= cpu_wdata;
      q <= mem[addr];
    end
  end

  assign tu0_rdata = g_bank[0].q;
  assign tu1_rdata = g_bank[1].q;
  assign cpu_rdata = rd_bank ? g_bank[1].q : g_bank[0].q;

  assert_err_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |=> !cpu_rvalid);
  assert_out_of_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !in_burst && !in_win) |-> !cpu_gnt);
  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt && !cpu_bank, tu0_gnt}) && $onehot0({cpu_gnt && cpu_bank, tu1_gnt}));
  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst |-> cpu_gnt);
  assert_tu0_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tu0_gnt |=> tu0_rvalid);
  assert_tu1_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tu1_gnt |=> tu1_rvalid);
  assert_cpu_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cpu_we) |=> cpu_rvalid);
  assert_indep_bank0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tu0_req && !(cpu_req && !cpu_bank)) |-> tu0_gnt);
  assert_indep_bank1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tu1_req && !(cpu_req && cpu_bank)) |-> tu1_gnt);
endmodule

// File: tb/dbuf_arbiter_bench.sv
module dbuf_arbiter_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [2:0] cpu_size = 0;
  logic [15:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic cpu_gnt, cpu_err, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic tu0_req = 0, tu1_req = 0;
  logic [10:0] tu0_addr = 0, tu1_addr = 0;
  logic tu0_gnt, tu0_rvalid, tu1_gnt, tu1_rvalid;
  logic [31:0] tu0_rdata, tu1_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dbuf_arbiter u_dbuf_arbiter (.*);

  // {size[2:0], addr[15:0], req, t0, t1, gnt, err, g0, g1}
  localparam logic [25:0] VEC [16] = '{
    {3'd2, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd2, 16'h1FFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd2, 16'h2000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd2, 16'h2000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd2, 16'h1FFC, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd6, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd7, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd3, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd5, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 16'h4000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd2, 16'h3FFC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic tu_read(input int bank, input logic [10:0] w, input logic [31:0] exp, input string tag);
    if (bank == 0) begin tu0_req = 1; tu0_addr = w; end
    else begin tu1_req = 1; tu1_addr = w; end
    #3;
    chk({tag, " gnt"}, bank == 0 ? tu0_gnt : tu1_gnt, 1);
    tick();
    tu0_req = 0; tu1_req = 0;
    chk({tag, " rvalid"}, bank == 0 ? tu0_rvalid : tu1_rvalid, 1);
    chk({tag, " data"}, bank == 0 ? tu0_rdata : tu1_rdata, exp);
  endtask

  task automatic cpu_error(input logic [2:0] sz, input logic [15:0] a, input string tag);
    cpu_req = 1; cpu_we = 1; cpu_size = sz; cpu_addr = a; cpu_wdata = 32'hDEAD_BEEF;
    #3;
    chk({tag, " err"}, cpu_err, 1);
    chk({tag, " gnt"}, cpu_gnt, 0);
    tick();
    cpu_req = 0; cpu_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 cpu_rvalid in reset", cpu_rvalid, 0);
    chk("R9 tu0_rvalid in reset", tu0_rvalid, 0);
    chk("R9 tu1_rvalid in reset", tu1_rvalid, 0);
    rst_n = 1;
    tick();
    chk("R9 idle gnt", cpu_gnt, 0);
    chk("R9 idle err", cpu_err, 0);
    tu0_req = 1; #3;
    chk("R9 no burst after reset", tu0_gnt, 1);
    tick(); tu0_req = 0; tick();

    // vector table: R1 R3 R4 R5 R8
    for (int i = 0; i < 16; i++) begin
      logic [25:0] v;
      v = VEC[i];
      cpu_size = v[25:23]; cpu_addr = v[22:7]; cpu_req = v[6];
      tu0_req = v[5]; tu1_req = v[4]; cpu_we = 0;
      #3;
      chk($sformatf("R1/R5/R8 vec%0d cpu_gnt", i), cpu_gnt, v[3]);
      chk($sformatf("R3/R4 vec%0d cpu_err", i), cpu_err, v[2]);
      chk($sformatf("R5/R8 vec%0d tu0_gnt", i), tu0_gnt, v[1]);
      chk($sformatf("R5/R8 vec%0d tu1_gnt", i), tu1_gnt, v[0]);
      tick();
      cpu_req = 0; tu0_req = 0; tu1_req = 0;
      tick();
    end

    // R6: 32-byte write burst to bank 0, reader arrives after first beat
    cpu_req = 1; cpu_we = 1; cpu_size = 5; cpu_addr = 16'h0040;
    for (int i = 0; i < 8; i++) begin
      cpu_wdata = 32'hA000_0000 + i;
      if (i == 1) begin tu0_req = 1; tu0_addr = 0; end
      #3;
      chk($sformatf("R6 beat%0d cpu_gnt", i), cpu_gnt, 1);
      if (i >= 1) chk($sformatf("R6 beat%0d tu0 held off", i), tu0_gnt, 0);
      tick();
    end
    cpu_req = 0; cpu_we = 0;
    #3;
    chk("R6 tu0 released after burst", tu0_gnt, 1);
    tick(); tu0_req = 0; tick();

    // R8/R2/R7: 16-byte write to bank 1 while bank 0 reader streams
    cpu_req = 1; cpu_we = 1; cpu_size = 4; cpu_addr = 16'h2100;
    for (int i = 0; i < 4; i++) begin
      cpu_wdata = 32'hB000_0000 + i;
      tu0_req = 1; tu0_addr = 11'h10 + 11'(i);
      #3;
      chk($sformatf("R2 bank1 beat%0d gnt", i), cpu_gnt, 1);
      chk($sformatf("R8 tu0 concurrent beat%0d", i), tu0_gnt, 1);
      tick();
      chk($sformatf("R7 tu0 rvalid beat%0d", i), tu0_rvalid, 1);
      chk($sformatf("R2 tu0 data word%0d", i), tu0_rdata, 32'hA000_0000 + i);
    end
    cpu_req = 0; cpu_we = 0; tu0_req = 0;
    tick();
    for (int i = 0; i < 4; i++)
      tu_read(1, 11'h40 + 11'(i), 32'hB000_0000 + i, $sformatf("R1 R2 bank1 word%0d", i));

    // R7: processor 8-byte read
    cpu_req = 1; cpu_we = 0; cpu_size = 3; cpu_addr = 16'h0048;
    for (int i = 0; i < 2; i++) begin
      #3;
      chk($sformatf("R2 cpu read beat%0d gnt", i), cpu_gnt, 1);
      tick();
      if (i == 1) cpu_req = 0;
      chk($sformatf("R7 cpu rvalid beat%0d", i), cpu_rvalid, 1);
      chk($sformatf("R7 cpu rdata beat%0d", i), cpu_rdata, 32'hA000_0002 + i);
    end
    tick();
    chk("R7 cpu rvalid drops", cpu_rvalid, 0);

    // R3/R4: refused writes leave RAM untouched
    cpu_error(3'd1, 16'h0040, "R3 halfword write");
    tu_read(0, 11'h10, 32'hA000_0000, "R3 word unchanged");
    cpu_error(3'd7, 16'h0040, "R3 size7 write");
    tu_read(0, 11'h10, 32'hA000_0000, "R3 word unchanged size7");
    cpu_error(3'd3, 16'h0044, "R4 misaligned write");
    tu_read(0, 11'h11, 32'hA000_0001, "R4 word unchanged misaligned");
    cpu_error(3'd2, 16'h4040, "R4 out of window write");
    tu_read(0, 11'h10, 32'hA000_0000, "R4 word unchanged alias");
    chk("R3 no rvalid after error", cpu_rvalid, 0);

    // R5: contention at burst start, reader wins, processor follows
    cpu_req = 1; cpu_we = 0; cpu_size = 3; cpu_addr = 16'h0040;
    tu0_req = 1; tu0_addr = 11'h17;
    #3;
    chk("R5 cpu waits", cpu_gnt, 0);
    chk("R5 reader wins", tu0_gnt, 1);
    tick();
    tu0_req = 0;
    chk("R5 reader data", tu0_rdata, 32'hA000_0007);
    for (int i = 0; i < 2; i++) begin
      #3;
      chk($sformatf("R5 cpu beat%0d after wait", i), cpu_gnt, 1);
      tick();
      if (i == 1) cpu_req = 0;
      chk($sformatf("R7 cpu data beat%0d after wait", i), cpu_rdata, 32'hA000_0000 + i);
    end

    // R8: both readers at once
    tu0_req = 1; tu0_addr = 11'h12; tu1_req = 1; tu1_addr = 11'h41;
    #3;
    chk("R8 both gnt tu0", tu0_gnt, 1);
    chk("R8 both gnt tu1", tu1_gnt, 1);
    tick();
    tu0_req = 0; tu1_req = 0;
    chk("R8 tu0 data", tu0_rdata, 32'hA000_0002);
    chk("R8 tu1 data", tu1_rdata, 32'hB000_0001);
    chk("R7 tu1 rvalid", tu1_rvalid, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule